// File: doc/BRIEF.md
# Compare Match Interval Timer

This block is a 16-bit periodic interval timer on a small word-addressed register bus. A free-running prescaler divides the peripheral clock and emits single-cycle enable pulses at one of four ratios. While the timer runs, each pulse advances an up-counter. When the counter equals a programmed compare constant, the next pulse returns the counter to zero and sets a sticky match flag. An interrupt request output follows that flag, gated by an enable bit.

Software programs the compare constant, chooses a ratio, and sets the run bit. It then services the flag with a two-step handshake. First it reads the status register and sees the flag at 1. Then it writes 0 to the flag bit. A bare write of 0 does not clear the flag, so a stray write cannot lose a pending event.

Bus map: word address 0 is the control register (bit 0 run, bit 1 interrupt enable). Address 1 is the status register. Address 2 is the counter. Address 3 is the compare constant. A write takes effect at the clock edge in the cycle where `bus_valid` and `bus_write` are both high. Read data is combinational and valid in the cycle where `bus_valid` is high and `bus_write` is low. Otherwise the read data is zero.

Top module: `cmt_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the compare constant reads 0xFFFF, the status register reads 0x0000, the control register reads 0x0002 (run 0, interrupt enable 1), and `irq` is 0.
- R2: The counter advances once every 4, 8, 16 or 64 clock cycles when status bits 1:0 are 00, 01, 10 or 11. The prescaler is free-running and produces pulses one cycle wide. A new select value applies from the next prescaler pulse onward.
- R3: While control bit 0 (run) is 0, the counter holds its value.
- R4: On a pulse while running, the counter increments by one. If the counter equals the compare constant on that pulse, it goes to 0x0000 instead and the flag is set in the same edge. A match therefore repeats every (constant + 1) pulses.
- R5: When a match and a valid clearing write fall on the same edge, the flag stays 1.
- R6: The flag clears only on a write of 0 to status bit 7 when the previous status-register access was a read that returned bit 7 = 1. Writing 1 to bit 7 has no effect. Writing 0 without that read has no effect. Any status write consumes the read.
- R7: Status layout: bit 7 is the flag, bit 6 is plain read/write storage, bits 5:2 always read 0, and bits 1:0 are the ratio select.
- R8: `irq` equals the flag ANDed with control bit 1.
- R9: The counter and the compare constant are readable and writable. A counter write on the same edge as a pulse wins over the increment and suppresses the match for that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when no read is active |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the spacing between counter steps for each ratio select. A prescaler with a wrong tap would show a spacing other than 4, 8, 16 or 64. It drives wrap-around with a compare constant of 2 and checks the 12-cycle match period and the flag rise at the moment of the wrap. An off-by-one compare would stretch or shorten that period.

The flag handshake is attacked three ways: a zero write with no prior read, a write of 1 after a read, and a clearing write swept across all four prescaler phases. In the sweep, exactly one attempt must keep the flag because a match lands on the same edge. A design that let the clear win would leave no attempt with the flag held. Counter writes are swept across the same phases, so an increment that overrode the write would show up as a readback one higher than written.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int CMT_DW      = 16;
    localparam int CMT_AW      = 2;
    localparam int CMT_MAX_DIV = 64;
    localparam int CMT_PRE_W   = $clog2(CMT_MAX_DIV);
    localparam int CMT_NSEL    = 4;

    typedef enum logic [1:0] {
        DIV_4  = 2'b00,
        DIV_8  = 2'b01,
        DIV_16 = 2'b10,
        DIV_64 = 2'b11
    } cmt_div_e;

    typedef enum logic [CMT_AW-1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_CNT  = 2'd2,
        A_CMP  = 2'd3
    } cmt_addr_e;

    typedef struct packed {
        logic     flag;
        logic     spare;
        logic [3:0] zero;
        cmt_div_e div;
    } cmt_stat_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_stat;
        logic wr_cnt;
        logic wr_cmp;
        logic rd_stat;
    } cmt_acc_t;

    // Low-bit mask of the prescaler for a select: all ones marks a pulse
    function automatic logic [CMT_PRE_W-1:0] div_mask(cmt_div_e d);
        case (d)
            DIV_4:   div_mask = CMT_PRE_W'(3);
            DIV_8:   div_mask = CMT_PRE_W'(7);
            DIV_16:  div_mask = CMT_PRE_W'(15);
            default: div_mask = CMT_PRE_W'(CMT_MAX_DIV - 1);
        endcase
    endfunction

endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale
    import cmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cmt_div_e div,
    output logic     tick
);
    logic [CMT_PRE_W-1:0] pre_q;
    logic [CMT_NSEL-1:0]  taps;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    // One tap per ratio; the select picks which one drives the pulse
    for (genvar g = 0; g < CMT_NSEL; g++) begin : g_tap
        assign taps[g] = &(pre_q | ~div_mask(cmt_div_e'(2'(g))));
    end

    assign tick = taps[div];
endmodule

// File: rtl/cmt_count.sv
module cmt_count
    import cmt_pkg::*;
#(
    parameter int DW = CMT_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic          wr_cnt,
    input  logic          wr_cmp,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt_q,
    output logic [DW-1:0] cmp_q,
    output logic          match
);
    logic adv;
    logic hit;

    assign adv   = run && tick;
    assign hit   = (cnt_q == cmp_q);
    assign match = adv && hit && !wr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (adv) begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= '1;
        else if (wr_cmp) cmp_q <= wdata;
    end
endmodule

// File: rtl/cmt_status.sv
module cmt_status
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic       wr_stat,
    input  logic       rd_stat,
    input  logic [7:0] wdata,
    input  logic       match,
    output cmt_stat_t  stat,
    output logic       run,
    output logic       irq_en
);
    logic     flag_q;
    logic     spare_q;
    logic     arm_q;
    logic     run_q;
    logic     ie_q;
    cmt_div_e div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            ie_q  <= 1'b1;
        end else if (wr_ctrl) begin
            run_q <= wdata[0];
            ie_q  <= wdata[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spare_q <= 1'b0;
            div_q   <= DIV_4;
        end else if (wr_stat) begin
            spare_q <= wdata[6];
            div_q   <= cmt_div_e'(wdata[1:0]);
        end
    end

    // A read that saw the flag high arms the clear; any status write disarms
    always_ff @(posedge clk) begin
        if (rst)                   arm_q <= 1'b0;
        else if (wr_stat)          arm_q <= 1'b0;
        else if (rd_stat && flag_q) arm_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                                 flag_q <= 1'b0;
        else if (match)                          flag_q <= 1'b1;
        else if (wr_stat && !wdata[7] && arm_q)  flag_q <= 1'b0;
    end

    always_comb begin
        stat       = '0;
        stat.flag  = flag_q;
        stat.spare = spare_q;
        stat.div   = div_q;
    end

    assign run    = run_q;
    assign irq_en = ie_q;
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int DW = CMT_DW,
    parameter int AW = CMT_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    cmt_acc_t      acc;
    cmt_stat_t     stat;
    logic          run;
    logic          irq_en;
    logic          tick;
    logic          match;
    logic          flag;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] cmp_q;

    always_comb begin
        acc = '0;
        if (bus_valid) begin
            unique case (cmt_addr_e'(bus_addr))
                A_CTRL: acc.wr_ctrl = bus_write;
                A_STAT: begin
                    acc.wr_stat = bus_write;
                    acc.rd_stat = !bus_write;
                end
                A_CNT:  acc.wr_cnt = bus_write;
                A_CMP:  acc.wr_cmp = bus_write;
                default: acc = '0;
            endcase
        end
    end

    cmt_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .div  (stat.div),
        .tick (tick)
    );

    cmt_count #(.DW(DW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (tick),
        .wr_cnt (acc.wr_cnt),
        .wr_cmp (acc.wr_cmp),
        .wdata  (bus_wdata),
        .cnt_q  (cnt_q),
        .cmp_q  (cmp_q),
        .match  (match)
    );

    cmt_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (acc.wr_ctrl),
        .wr_stat (acc.wr_stat),
        .rd_stat (acc.rd_stat),
        .wdata   (bus_wdata[7:0]),
        .match   (match),
        .stat    (stat),
        .run     (run),
        .irq_en  (irq_en)
    );

    assign flag = stat.flag;
    assign irq  = flag && irq_en;

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            unique case (cmt_addr_e'(bus_addr))
                A_CTRL:  bus_rdata[1:0] = {irq_en, run};
                A_STAT:  bus_rdata[7:0] = stat;
                A_CNT:   bus_rdata = cnt_q;
                A_CMP:   bus_rdata = cmp_q;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
    parameter int DW = 16,
    parameter int AW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_valid,
    input logic          bus_write,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] cnt_q,
    input logic [DW-1:0] cmp_q,
    input logic          run,
    input logic          tick,
    input logic          match,
    input logic          flag,
    input logic          irq
);
    logic cnt_wr;
    logic cmp_wr;
    logic clr_try;

    assign cnt_wr  = bus_valid && bus_write && (bus_addr == AW'(2));
    assign cmp_wr  = bus_valid && bus_write && (bus_addr == AW'(3));
    assign clr_try = bus_valid && bus_write && (bus_addr == AW'(1)) && !bus_wdata[7];

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt_q)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !cnt_wr && cnt_q != cmp_q) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        match |=> (cnt_q == '0)); // R4
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        match |=> flag); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_try) |=> flag); // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag); // R8
    AST_CNT_WRITE: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_q == $past(bus_wdata))); // R9
    AST_CMP_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> (cmp_q == $past(bus_wdata))); // R9
endmodule

bind cmt_timer cmt_timer_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .run       (run),
    .tick      (tick),
    .match     (match),
    .flag      (flag),
    .irq       (irq)
);

// File: tb/cmt_timer_tb.sv
module cmt_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;

    localparam logic [1:0] AD_CTRL = 2'd0;
    localparam logic [1:0] AD_STAT = 2'd1;
    localparam logic [1:0] AD_CNT  = 2'd2;
    localparam logic [1:0] AD_CMP  = 2'd3;

    always #10 clk = ~clk;

    cmt_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // Combinational look at the counter with no clock edge in between
    task automatic peek_cnt(output logic [15:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AD_CNT;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic measure_gap(output int gap);
        logic [15:0] prev;
        int c;
        gap = -1;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AD_CNT;
        #1 prev = bus_rdata;
        c = 0;
        while (bus_rdata == prev && c < 200) begin
            @(negedge clk); #1; c++;
        end
        prev = bus_rdata;
        c = 0;
        while (bus_rdata == prev && c < 200) begin
            @(negedge clk); #1; c++;
        end
        gap = c;
        bus_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(AD_CNT, d);  check("R1 counter", d, 16'h0000);
        rd(AD_CMP, d);  check("R1 constant", d, 16'hFFFF);
        rd(AD_STAT, d); check("R1 status", d, 16'h0000);
        rd(AD_CTRL, d); check("R1 control", d, 16'h0002);
        check("R1 irq", irq, 1'b0);
    endtask

    task automatic t_ratio;
        int gap;
        int ratio[4] = '{4, 8, 16, 64};
        wr(AD_CTRL, 16'h0003);
        for (int s = 0; s < 4; s++) begin
            wr(AD_STAT, 16'(s));
            measure_gap(gap);
            check($sformatf("R2 gap sel %0d", s), gap, ratio[s]);
        end
        wr(AD_CTRL, 16'h0002);
    endtask

    task automatic t_stopped;
        logic [15:0] a, b;
        wr(AD_STAT, 16'h0000);
        rd(AD_CNT, a);
        repeat (100) @(negedge clk);
        rd(AD_CNT, b);
        check("R3 hold while stopped", b, a);
    endtask

    task automatic t_wrap;
        logic [15:0] prev, cur;
        int ev, t0, t, over;
        wr(AD_CMP, 16'd2);
        wr(AD_CNT, 16'd0);
        wr(AD_CTRL, 16'h0003);
        ev = 0; t = 0; t0 = 0; over = 0;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AD_CNT;
        #1 prev = bus_rdata;
        while (ev < 2 && t < 200) begin
            @(negedge clk); #1; t++;
            cur = bus_rdata;
            if (cur > 16'd2) over++;
            if (prev == 16'd2 && cur == 16'd0) begin
                if (ev == 0) begin
                    check("R4 flag rises at wrap", irq, 1'b1);
                    t0 = t;
                end else begin
                    check("R4 match period", t - t0, 12);
                end
                ev++;
            end else if (ev == 0) begin
                if (irq !== 1'b0) check("R4 flag before first wrap", irq, 1'b0);
            end
            prev = cur;
        end
        bus_valid = 1'b0;
        check("R4 two wraps seen", ev, 2);
        check("R4 counter stays within constant", over, 0);
        wr(AD_CTRL, 16'h0002);
    endtask

    task automatic t_flag;
        logic [15:0] d;
        wr(AD_STAT, 16'h0000);
        check("R6 zero write without read", irq, 1'b1);
        rd(AD_STAT, d);
        wr(AD_STAT, 16'h0080);
        check("R6 write of one ignored", irq, 1'b1);
        wr(AD_CTRL, 16'h0000);
        check("R8 irq masked", irq, 1'b0);
        wr(AD_CTRL, 16'h0002);
        check("R8 irq unmasked", irq, 1'b1);
        rd(AD_STAT, d);
        check("R6 read shows flag", d, 16'h0080);
        wr(AD_STAT, 16'h0000);
        check("R6 read then zero clears", irq, 1'b0);
    endtask

    task automatic t_layout;
        logic [15:0] d;
        wr(AD_STAT, 16'h00FF);
        rd(AD_STAT, d);
        check("R7 layout readback", d, 16'h0043);
        wr(AD_STAT, 16'h0000);
        rd(AD_STAT, d);
        check("R7 spare bit clears", d, 16'h0000);
    endtask

    task automatic t_set_wins;
        logic [15:0] d;
        int held;
        wr(AD_CMP, 16'd0);
        wr(AD_CNT, 16'd0);
        wr(AD_CTRL, 16'h0003);
        repeat (8) @(negedge clk);
        held = 0;
        for (int i = 0; i < 4; i++) begin
            rd(AD_STAT, d);
            check("R5 flag seen before clear", d[7], 1'b1);
            wr(AD_STAT, 16'h0000);
            #1 if (irq) held++;
            repeat (5) @(negedge clk);
        end
        check("R5 set beats clear in one phase", held, 1);
        wr(AD_CTRL, 16'h0002);
    endtask

    task automatic t_cnt_write;
        logic [15:0] d;
        wr(AD_CMP, 16'hFFFF);
        wr(AD_CTRL, 16'h0003);
        for (int i = 0; i < 4; i++) begin
            wr(AD_CNT, 16'h1230 + 16'(i));
            peek_cnt(d);
            check($sformatf("R9 write wins phase %0d", i), d, 16'h1230 + 16'(i));
            @(negedge clk);
        end
        wr(AD_CTRL, 16'h0002);
        wr(AD_CMP, 16'h00A5);
        rd(AD_CMP, d);
        check("R9 constant readback", d, 16'h00A5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ratio();
        t_stopped();
        t_wrap();
        t_flag();
        t_layout();
        t_set_wins();
        t_cnt_write();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule